// File: doc/BRIEF.md
# ALU-Shifter Function Unit

This block is the purely combinational function unit of a register-based datapath. It takes two operands of `WIDTH` bits and a 4-bit function code. It returns one result of the same width together with four status flags: overflow, carry, negative and zero. Inside, three engines work in parallel on the operands:

- an adder whose second input is picked from zero, B, inverted B or all ones, with a carry-in;
- a bitwise logic unit;
- a one-place shifter that acts on B.

A final multiplexer chooses which engine drives the result.

The function code is dense. Its low bits steer the adder input, the carry-in and the logic operation all at once. Its top two bits choose between the shifter and the arithmetic/logic path. A sequencer can therefore issue any of the fifteen operations with a single 4-bit field. The sixteenth code gives a zero result.

Top module: `fu_core`

## Requirements
- R1: Codes 0000 through 0111 give A, A+1, A+B, A+B+1, A+~B, A+~B+1, A−1 and A, in that order, truncated to WIDTH bits. The adder forms A+Y+cin, with cin equal to code bit 0 and Y chosen by code bits 2:1 (00 zero, 01 B, 10 ~B, 11 all ones).
- R2: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R3: Code 1100 passes B unchanged. Code 1101 moves B one place toward the LSB and code 1110 moves B one place toward the MSB. The vacated bit is 0 in both shifts.
- R4: Code 1111 gives a result of all zeros.
- R5: For codes 0xxx, the carry flag equals the carry out of the adder's most significant bit. For every code 1xxx it is 0.
- R6: For codes 0xxx, the overflow flag is 1 exactly when A and Y have equal MSBs and the sum's MSB differs from them. For every code 1xxx it is 0.
- R7: The negative flag equals the MSB of the result for every code.
- R8: The zero flag is 1 exactly when every result bit is 0, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, also the shifter's input |
| func_sel | input | 4 | Function code |
| result | output | WIDTH | Selected result |
| flag_v | output | 1 | Signed overflow from the adder |
| flag_c | output | 1 | Carry out from the adder |
| flag_n | output | 1 | MSB of the result |
| flag_z | output | 1 | Result is all zeros |

## Verification
The unit holds no state. A wrong decode of the function code, a misrouted carry-in or an adder input taken from the wrong source therefore shows on the result and flags in the same evaluation, with no delay in cycles. Operand pairs are chosen so that every code is told apart from its neighbours:

- carries out of the MSB;
- signed overflow in both directions;
- results that become exactly zero;
- shifts that drop a set bit off either end.

Flags that must be forced low for logic and shift codes are checked with operands that would raise them on the adder path.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [3:0] {
        FS_PASS_A   = 4'b0000,
        FS_INC      = 4'b0001,
        FS_ADD      = 4'b0010,
        FS_ADD_C    = 4'b0011,
        FS_ADD_NB   = 4'b0100,
        FS_SUB      = 4'b0101,
        FS_DEC      = 4'b0110,
        FS_PASS_A2  = 4'b0111,
        FS_AND      = 4'b1000,
        FS_OR       = 4'b1001,
        FS_XOR      = 4'b1010,
        FS_NOT      = 4'b1011,
        FS_PASS_B   = 4'b1100,
        FS_SHR      = 4'b1101,
        FS_SHL      = 4'b1110,
        FS_CLEAR    = 4'b1111
    } fs_e;

    typedef enum logic [1:0] {
        Y_ZERO = 2'b00,
        Y_B    = 2'b01,
        Y_NOTB = 2'b10,
        Y_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_ZERO  = 2'b11
    } shop_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'b00,
        SRC_LOGIC = 2'b01,
        SRC_SHIFT = 2'b10
    } src_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } status_t;

    typedef struct packed {
        src_e  src;
        ysel_e ysel;
        logic  cin;
        lop_e  lop;
        shop_e shop;
    } decode_t;

    function automatic decode_t decode_fs(input logic [3:0] fs);
        decode_t d;
        if (fs[3] && fs[2])
            d.src = SRC_SHIFT;
        else if (fs[3])
            d.src = SRC_LOGIC;
        else
            d.src = SRC_ARITH;
        d.ysel = ysel_e'(fs[2:1]);
        d.cin  = fs[0];
        d.lop  = lop_e'(fs[1:0]);
        d.shop = shop_e'(fs[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  ysel_e        ysel,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] y;
    logic [W:0]   wide;

    always_comb begin
        unique case (ysel)
            Y_ZERO:  y = '0;
            Y_B:     y = b;
            Y_NOTB:  y = ~b;
            default: y = '1;
        endcase
    end

    assign wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (a[MSB] == y[MSB]) && (wide[MSB] != a[MSB]);
endmodule

// File: rtl/fu_logic.sv
module fu_logic
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lop_e         lop,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (lop)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] b,
    input  shop_e        shop,
    output logic [W-1:0] res
);
    localparam int MSB = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_hi;
        logic from_lo;
        if (i == MSB) begin : g_top
            assign from_hi = 1'b0;
        end else begin : g_mid_hi
            assign from_hi = b[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_lo = 1'b0;
        end else begin : g_mid_lo
            assign from_lo = b[i-1];
        end
        always_comb begin
            unique case (shop)
                SH_PASS:  res[i] = b[i];
                SH_RIGHT: res[i] = from_hi;
                SH_LEFT:  res[i] = from_lo;
                default:  res[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fu_core.sv
module fu_core
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z
);
    localparam int MSB = WIDTH - 1;

    decode_t          dec;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    logic             arith_cout;
    logic             arith_ovf;
    status_t          st;

    assign dec = decode_fs(func_sel);

    fu_arith #(.W(WIDTH)) u_arith (
        .a    (op_a),
        .b    (op_b),
        .ysel (dec.ysel),
        .cin  (dec.cin),
        .sum  (arith_res),
        .cout (arith_cout),
        .ovf  (arith_ovf)
    );

    fu_logic #(.W(WIDTH)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .lop (dec.lop),
        .res (logic_res)
    );

    fu_shift #(.W(WIDTH)) u_shift (
        .b    (op_b),
        .shop (dec.shop),
        .res  (shift_res)
    );

    always_comb begin
        unique case (dec.src)
            SRC_ARITH: result = arith_res;
            SRC_LOGIC: result = logic_res;
            default:   result = shift_res;
        endcase
    end

    always_comb begin
        st   = '0;
        st.n = result[MSB];
        st.z = ~|result;
        if (dec.src == SRC_ARITH) begin
            st.c = arith_cout;
            st.v = arith_ovf;
        end
    end

    assign flag_v = st.v;
    assign flag_c = st.c;
    assign flag_n = st.n;
    assign flag_z = st.z;
endmodule

// File: rtl/fu_core_chk.sv
module fu_core_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [3:0]   fs,
    input logic [W-1:0] f,
    input logic         v,
    input logic         c,
    input logic         n,
    input logic         z
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (fs == 4'b0001) begin
            p_increment_r1: assert (f == a + ONE);
        end
        if (fs == 4'b1011) begin
            p_invert_r2: assert ((f ^ a) == '1);
        end
        if (fs == 4'b1100) begin
            p_pass_b_r3: assert (f == b);
        end
        if (fs == 4'b1101) begin
            p_right_fill_r3: assert (f[W-1] == 1'b0);
        end
        if (fs == 4'b1110) begin
            p_left_fill_r3: assert (f[0] == 1'b0);
        end
        if (fs == 4'b1111) begin
            p_unused_zero_r4: assert (f == '0 && z);
        end
        if (fs[3]) begin
            p_no_carry_r5: assert (!c);
            p_no_overflow_r6: assert (!v);
        end
        p_negative_r7: assert (n == f[W-1]);
        p_zero_r8: assert (z == (f == '0));
    end
endmodule

bind fu_core fu_core_chk #(.W(WIDTH)) u_fu_core_chk (
    .a  (op_a),
    .b  (op_b),
    .fs (func_sel),
    .f  (result),
    .v  (flag_v),
    .c  (flag_c),
    .n  (flag_n),
    .z  (flag_z)
);

// File: tb/fu_core_bench.sv
module fu_core_bench;
    localparam int W = 8;
    localparam int NV = 24;

    // {fs, a, b, expected f, expected v c n z}
    localparam logic [31:0] VEC [NV] = '{
        {4'h0, 8'h00, 8'h00, 8'h00, 4'b0001},
        {4'h0, 8'h80, 8'h11, 8'h80, 4'b0010},
        {4'h1, 8'h7F, 8'h00, 8'h80, 4'b1010},
        {4'h1, 8'hFF, 8'h00, 8'h00, 4'b0101},
        {4'h2, 8'h50, 8'h50, 8'hA0, 4'b1010},
        {4'h2, 8'h80, 8'h80, 8'h00, 4'b1101},
        {4'h3, 8'h10, 8'h20, 8'h31, 4'b0000},
        {4'h4, 8'h05, 8'h03, 8'h01, 4'b0100},
        {4'h5, 8'h05, 8'h05, 8'h00, 4'b0101},
        {4'h5, 8'h03, 8'h05, 8'hFE, 4'b0010},
        {4'h5, 8'h80, 8'h01, 8'h7F, 4'b1100},
        {4'h6, 8'h00, 8'h00, 8'hFF, 4'b0010},
        {4'h6, 8'h80, 8'h00, 8'h7F, 4'b1100},
        {4'h7, 8'h3C, 8'h00, 8'h3C, 4'b0100},
        {4'h8, 8'hF0, 8'h3C, 8'h30, 4'b0000},
        {4'h9, 8'hF0, 8'h3C, 8'hFC, 4'b0010},
        {4'hA, 8'hF0, 8'h3C, 8'hCC, 4'b0010},
        {4'hB, 8'hF0, 8'h3C, 8'h0F, 4'b0000},
        {4'hB, 8'hFF, 8'h00, 8'h00, 4'b0001},
        {4'hC, 8'hFF, 8'h81, 8'h81, 4'b0010},
        {4'hD, 8'hFF, 8'h81, 8'h40, 4'b0000},
        {4'hE, 8'hFF, 8'h81, 8'h02, 4'b0000},
        {4'hE, 8'hFF, 8'h80, 8'h00, 4'b0001},
        {4'hF, 8'hFF, 8'hFF, 8'h00, 4'b0001}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   fs = '0;
    logic [W-1:0] f;
    logic         v, c, n, z;
    int           checks = 0;
    int           fails = 0;
    int           cycles = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    fu_core #(.WIDTH(W)) u_fu_core (
        .op_a     (a),
        .op_b     (b),
        .func_sel (fs),
        .result   (f),
        .flag_v   (v),
        .flag_c   (c),
        .flag_n   (n),
        .flag_z   (z)
    );

    function automatic string tag_of(input logic [3:0] code);
        if (code == 4'hF) return "R4";
        if (code[3] && code[2]) return "R3";
        if (code[3]) return "R2";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [W-1:0] ef,
                         input logic [3:0] eflags);
        checks++;
        if (f !== ef || {v, c, n, z} !== eflags) begin
            fails++;
            $display("FAIL %s fs=%h a=%h b=%h: got f=%h vcnz=%b, expected f=%h vcnz=%b",
                     req, fs, a, b, f, {v, c, n, z}, ef, eflags);
        end
    endtask

    task automatic apply(input logic [3:0] code, input logic [W-1:0] xa,
                         input logic [W-1:0] xb);
        @(negedge clk);
        fs = code;
        a  = xa;
        b  = xb;
        #1;
    endtask

    // Independent reference built from the requirement text
    task automatic model(input logic [3:0] code, input logic [W-1:0] xa,
                         input logic [W-1:0] xb, output logic [W-1:0] rf,
                         output logic [3:0] rflags);
        int ya;
        int yy;
        int ci;
        int total;
        int sgn;
        logic rv, rc;
        rv = 1'b0;
        rc = 1'b0;
        rf = '0;
        if (!code[3]) begin
            case (code[2:1])
                2'b00:   yy = 0;
                2'b01:   yy = int'(xb);
                2'b10:   yy = 255 - int'(xb);
                default: yy = 255;
            endcase
            ya = int'(xa);
            ci = int'(code[0]);
            total = ya + yy + ci;
            rf = W'(total);
            rc = (total > 255);
            sgn = (ya > 127 ? ya - 256 : ya) + (yy > 127 ? yy - 256 : yy) + ci;
            rv = (sgn > 127) || (sgn < -128);
        end else begin
            case (code[2:0])
                3'b000: rf = xa & xb;
                3'b001: rf = xa | xb;
                3'b010: rf = xa ^ xb;
                3'b011: rf = ~xa;
                3'b100: rf = xb;
                3'b101: rf = xb >> 1;
                3'b110: rf = xb << 1;
                default: rf = '0;
            endcase
        end
        rflags = {rv, rc, rf[W-1], rf == '0};
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [W-1:0] rf;
        logic [3:0]   rfl;
        logic [W-1:0] pa [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h5A, 8'h01};
        logic [W-1:0] pb [6] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h7F};

        // reset: zero inputs give a zero pass-through (R1, R8)
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R8 reset-state", 8'h00, 4'b0001);
        rst = 1'b0;

        // vector table covers R1..R8 with hand-worked results
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12]);
            check(tag_of(VEC[i][31:28]), VEC[i][11:4], VEC[i][3:0]);
        end

        // every code against the reference, operand pairs that stress R5 R6 R7
        for (int code = 0; code < 16; code++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    apply(4'(code), pa[ia], pb[ib]);
                    model(4'(code), pa[ia], pb[ib], rf, rfl);
                    check(code >= 8 ? "R5 R6 gated" : "R5 R6 adder", rf, rfl);
                end
            end
        end

        // R6: logic code on operands that overflow on the adder path gives v=0
        apply(4'b1001, 8'h7F, 8'h01);
        check("R6 logic clears v", 8'h7F, 4'b0000);
        // R5: shift with MSB dropped gives c=0
        apply(4'b1110, 8'hFF, 8'hFF);
        check("R5 shift clears c", 8'hFE, 4'b0010);
        // R7: negative follows MSB of a shift result
        apply(4'b1101, 8'h00, 8'hFE);
        check("R7 right shift msb", 8'h7F, 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule